// File: doc/BRIEF.md
# Horizontal Panel Scan Timing Generator

This block produces the horizontal drive waveforms for an active-matrix display panel whose column driver takes six video channels in parallel. From a system clock and a per-line sync pulse it builds a scan start pulse and a pair of antiphase shift clocks. It also emits six one-cycle sample strobes, which an external delay stage uses to phase-align the six channels. The shift clock is the system clock divided by a parameter (eight by default, so a 20 MHz system clock gives a 2.5 MHz shift clock). Each shift clock period moves the panel six dots along the line.

When the line sync arrives, the block captures two settings: a start offset in system cycles and a line length in shift clock periods. It waits out the offset and then raises the start pulse. The pulse brackets the first rising edge of the reference shift clock by half a period on each side, so it has setup and hold margins of several system cycles. The shift clocks then run for exactly the programmed number of periods, with a line-active flag covering that window, and afterwards return to a fixed idle level. A direction bit chooses right or left scan. Left scan fires the sample strobes in the reverse channel order.

Top module: `hscan_timing_gen`

## Requirements
- R1: During and directly after reset, and whenever no line is running, scan_start=0, shclk_a=0, shclk_b=1, chan_strobe=0 and line_active=0.
- R2: When line_sync is sampled high at rising edge E0 with ofs_cfg=O, scan_start is first high after edge E(O+2), where E(n) is the n-th rising edge after E0.
- R3: For a nonzero line length, scan_start stays high for exactly DIV system cycles: DIV/2 cycles before the first rise of shclk_a and DIV/2 cycles from that rise on.
- R4: shclk_a has a period of DIV system cycles and is high for the first DIV/2 cycles of each period; its first rise follows edge E(O+2+DIV/2); shclk_b is the exact complement of shclk_a in every cycle.
- R5: With a captured line length L>0, shclk_a rises exactly L times per line, and line_active is high for exactly L*DIV cycles starting in the cycle of the first shclk_a rise.
- R6: In right scan (dir_right=1), chan_strobe bit k pulses for one cycle in every shift period, at phase floor(k*DIV/NCH), where phase 0 is the cycle in which shclk_a rises; the channels therefore fire in the order 0,1,...,NCH-1.
- R7: In left scan (dir_right=0), chan_strobe bit k fires at phase floor((NCH-1-k)*DIV/NCH), so the firing order is NCH-1 down to 0.
- R8: After the last shift period of a line, all outputs return to the R1 idle levels until the next line_sync.
- R9: A line_sync arriving while a line is in progress abandons that line: from the second edge after the sync the outputs are idle, and the new line follows R2 to R7 counted from the new sync.
- R10: A captured line length of 0 gives a scan_start pulse of DIV/2 cycles and no shift clocks, strobes or line_active.
- R11: ofs_cfg and len_cfg are captured only at line_sync; changing them during a line has no effect on that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_sync | input | 1 | One-cycle pulse that starts a horizontal line |
| dir_right | input | 1 | 1 = right scan, 0 = left scan; held static during a frame |
| ofs_cfg | input | OFS_W | Start offset in system cycles, captured at line_sync |
| len_cfg | input | LEN_W | Line length in shift clock periods, captured at line_sync |
| scan_start | output | 1 | Horizontal start pulse |
| shclk_a | output | 1 | Reference shift clock |
| shclk_b | output | 1 | Complementary shift clock |
| chan_strobe | output | NCH | Per-channel sample strobes |
| line_active | output | 1 | High while the shift clocks run |

## Verification
The bench uses the defaults DIV=8 and NCH=6. With these values the strobe slots fall at phases 0,1,2,4,5,6, which are unevenly spaced, so a slot formula that is wrong by one rounding step is caught. OFS_W=LEN_W=8 allow a full 108-period line to run alongside a zero offset, a zero length and single-period lines. The same sizes also let the bench restart a line mid-run and change the configuration inputs while a line is in progress, in both scan directions.

// File: rtl/hscan_pkg.sv
package hscan_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_LEAD = 2'd2,
    ST_RUN  = 2'd3
  } seq_state_t;

  // Phase slot of a strobe position inside one shift period
  function automatic int unsigned strobe_slot(input int unsigned pos,
                                              input int unsigned div,
                                              input int unsigned nch);
    return (pos * div) / nch;
  endfunction

endpackage

// File: rtl/hscan_seq.sv
module hscan_seq
  import hscan_pkg::*;
#(
  parameter int DIV   = 8,
  parameter int OFS_W = 8,
  parameter int LEN_W = 8,
  localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1,
  localparam int HALF = DIV / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_sync,
  input  logic [OFS_W-1:0] ofs_cfg,
  input  logic [LEN_W-1:0] len_cfg,
  output seq_state_t       state,
  output logic [PH_W-1:0]  phase,
  output logic             first_period
);

  seq_state_t       st_q;
  logic [OFS_W-1:0] ofs_cnt;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] per_q;
  logic [PH_W-1:0]  ph_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      ofs_cnt <= '0;
      len_q   <= '0;
      per_q   <= '0;
      ph_q    <= '0;
    end else if (line_sync) begin
      st_q    <= ST_WAIT;
      ofs_cnt <= ofs_cfg;
      len_q   <= len_cfg;
      per_q   <= '0;
      ph_q    <= '0;
    end else begin
      case (st_q)
        ST_WAIT: begin
          if (ofs_cnt == '0) begin
            st_q <= ST_LEAD;
            ph_q <= '0;
          end else begin
            ofs_cnt <= ofs_cnt - 1'b1;
          end
        end
        ST_LEAD: begin
          if (ph_q == PH_W'(HALF - 1)) begin
            ph_q  <= '0;
            per_q <= '0;
            st_q  <= (len_q == '0) ? ST_IDLE : ST_RUN;
          end else begin
            ph_q <= ph_q + 1'b1;
          end
        end
        ST_RUN: begin
          if (ph_q == PH_W'(DIV - 1)) begin
            ph_q <= '0;
            if (per_q == len_q - LEN_W'(1)) begin
              st_q <= ST_IDLE;
            end else begin
              per_q <= per_q + 1'b1;
            end
          end else begin
            ph_q <= ph_q + 1'b1;
          end
        end
        default: begin
          ph_q <= '0;
        end
      endcase
    end
  end

  assign state        = st_q;
  assign phase        = ph_q;
  assign first_period = (per_q == '0);

  // R4: the phase counter never leaves one shift period
  p_phase_bound_r4: assert property (@(posedge clk) disable iff (rst)
    32'(ph_q) < DIV);

  // R10: a zero length never reaches the running state
  p_run_nonzero_r10: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN) |-> (len_q != '0));

  // R2: the wait state is left only through the lead-in
  p_wait_to_lead_r2: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WAIT && !line_sync && ofs_cnt == '0) |=> (st_q == ST_LEAD));

endmodule

// File: rtl/hscan_strobe.sv
module hscan_strobe
  import hscan_pkg::*;
#(
  parameter int DIV  = 8,
  parameter int NCH  = 6,
  localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1
) (
  input  logic            run,
  input  logic            dir_right,
  input  logic [PH_W-1:0] phase,
  output logic [NCH-1:0]  hit
);

  for (genvar k = 0; k < NCH; k++) begin : g_chan
    localparam int unsigned RSLOT = strobe_slot(k, DIV, NCH);
    localparam int unsigned LSLOT = strobe_slot(NCH - 1 - k, DIV, NCH);
    logic [PH_W-1:0] slot;
    assign slot   = dir_right ? PH_W'(RSLOT) : PH_W'(LSLOT);
    assign hit[k] = run && (phase == slot);
  end

endmodule

// File: rtl/hscan_outreg.sv
module hscan_outreg
  import hscan_pkg::*;
#(
  parameter int DIV  = 8,
  parameter int NCH  = 6,
  localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1,
  localparam int HALF = DIV / 2
) (
  input  logic            clk,
  input  logic            rst,
  input  seq_state_t      state,
  input  logic [PH_W-1:0] phase,
  input  logic            first_period,
  input  logic [NCH-1:0]  hit,
  output logic            scan_start,
  output logic            shclk_a,
  output logic            shclk_b,
  output logic [NCH-1:0]  chan_strobe,
  output logic            line_active
);

  logic run_n, clk_n, start_n;

  always_comb begin
    run_n   = (state == ST_RUN);
    clk_n   = run_n && (phase < PH_W'(HALF));
    start_n = (state == ST_LEAD) || (run_n && first_period && (phase < PH_W'(HALF)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scan_start  <= 1'b0;
      shclk_a     <= 1'b0;
      shclk_b     <= 1'b1;
      chan_strobe <= '0;
      line_active <= 1'b0;
    end else begin
      scan_start  <= start_n;
      shclk_a     <= clk_n;
      shclk_b     <= !clk_n;
      chan_strobe <= hit;
      line_active <= run_n;
    end
  end

  // R4: the two shift clocks are exact complements
  p_clk_complement_r4: assert property (@(posedge clk) disable iff (rst)
    shclk_b == !shclk_a);

  // R3: the start pulse rises while the reference clock is still idle
  p_start_setup_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(scan_start) |-> (!shclk_a && !line_active));

  // R6: at most one channel strobe per cycle
  p_strobe_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(chan_strobe));

  // R5: strobes appear only inside the active window
  p_strobe_in_line_r5: assert property (@(posedge clk) disable iff (rst)
    (chan_strobe != '0) |-> line_active);

  // R8: outside the active window the reference clock stays low
  p_idle_clock_r8: assert property (@(posedge clk) disable iff (rst)
    !line_active |-> !shclk_a);

endmodule

// File: rtl/hscan_timing_gen.sv
module hscan_timing_gen
  import hscan_pkg::*;
#(
  parameter int DIV   = 8,
  parameter int NCH   = 6,
  parameter int OFS_W = 8,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_sync,
  input  logic             dir_right,
  input  logic [OFS_W-1:0] ofs_cfg,
  input  logic [LEN_W-1:0] len_cfg,
  output logic             scan_start,
  output logic             shclk_a,
  output logic             shclk_b,
  output logic [NCH-1:0]   chan_strobe,
  output logic             line_active
);

  localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1;

  seq_state_t      state;
  logic [PH_W-1:0] phase;
  logic            first_period;
  logic [NCH-1:0]  hit;

  hscan_seq #(.DIV(DIV), .OFS_W(OFS_W), .LEN_W(LEN_W)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .line_sync    (line_sync),
    .ofs_cfg      (ofs_cfg),
    .len_cfg      (len_cfg),
    .state        (state),
    .phase        (phase),
    .first_period (first_period)
  );

  hscan_strobe #(.DIV(DIV), .NCH(NCH)) u_strobe (
    .run       (state == ST_RUN),
    .dir_right (dir_right),
    .phase     (phase),
    .hit       (hit)
  );

  hscan_outreg #(.DIV(DIV), .NCH(NCH)) u_out (
    .clk          (clk),
    .rst          (rst),
    .state        (state),
    .phase        (phase),
    .first_period (first_period),
    .hit          (hit),
    .scan_start   (scan_start),
    .shclk_a      (shclk_a),
    .shclk_b      (shclk_b),
    .chan_strobe  (chan_strobe),
    .line_active  (line_active)
  );

endmodule

// File: tb/sim_hscan_timing_gen.sv
module sim_hscan_timing_gen;

  localparam int DIV  = 8;
  localparam int NCH  = 6;
  localparam int HALF = DIV / 2;
  localparam int VW   = NCH + 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_sync = 1'b0;
  logic dir_right = 1'b1;
  logic [7:0] ofs_cfg = '0;
  logic [7:0] len_cfg = '0;
  logic scan_start, shclk_a, shclk_b, line_active;
  logic [NCH-1:0] chan_strobe;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit mon_on = 0;

  always #2 clk = ~clk;

  hscan_timing_gen #(.DIV(DIV), .NCH(NCH), .OFS_W(8), .LEN_W(8)) u0 (
    .clk(clk), .rst(rst), .line_sync(line_sync), .dir_right(dir_right),
    .ofs_cfg(ofs_cfg), .len_cfg(len_cfg), .scan_start(scan_start),
    .shclk_a(shclk_a), .shclk_b(shclk_b), .chan_strobe(chan_strobe),
    .line_active(line_active)
  );

  // Expected output after the n-th edge following the sync edge.
  // Layout: {start, clk_a, clk_b, active, strobe}
  function automatic logic [VW-1:0] model(int n, int o, int l, bit dr);
    logic [VW-1:0] v;
    int base, r, ph, pos;
    v = '0;
    v[NCH+1] = 1'b1;
    if (n >= o + 2 && n <= o + 1 + ((l == 0) ? HALF : DIV)) v[NCH+3] = 1'b1;
    base = o + 2 + HALF;
    if (l > 0 && n >= base && n < base + l * DIV) begin
      r = n - base;
      ph = r % DIV;
      v[NCH] = 1'b1;
      if (ph < HALF) begin
        v[NCH+2] = 1'b1;
        v[NCH+1] = 1'b0;
      end
      for (int k = 0; k < NCH; k++) begin
        pos = dr ? k : NCH - 1 - k;
        if (ph == (pos * DIV) / NCH) v[k] = 1'b1;
      end
    end
    return v;
  endfunction

  logic [VW-1:0] exp_q[$];
  string tag_q[$];
  string scen = "R1";
  int n_cur = 1000000;
  int o_cur = 0, l_cur = 0;
  bit d_cur = 1;

  // Driver: one system cycle, pushes the expected outputs after the next edge
  task automatic step(input bit sync, input int o_new, input int l_new, input bit d_new);
    logic [VW-1:0] e;
    line_sync = sync;
    if (sync) begin
      e = model(n_cur + 1, o_cur, l_cur, d_cur);
      n_cur = 0;
      o_cur = o_new;
      l_cur = l_new;
      d_cur = d_new;
    end else begin
      if (n_cur < 1000000) n_cur++;
      e = model(n_cur, o_cur, l_cur, d_cur);
    end
    exp_q.push_back(e);
    tag_q.push_back(scen);
    @(negedge clk);
    line_sync = 1'b0;
  endtask

  // Monitor: counts and order tracking
  int rise_cnt = 0;
  int order_q[$];
  logic prev_a = 1'b0;

  always @(posedge clk) begin
    logic [VW-1:0] got, e;
    string t;
    #1;
    if (mon_on && exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      got = {scan_start, shclk_a, shclk_b, line_active, chan_strobe};
      checks++;
      if (got !== e) begin
        errors++;
        if (got[NCH+3] !== e[NCH+3])
          $display("FAIL R2/R3 (%s) scan_start got %b exp %b at t=%0t", t, got[NCH+3], e[NCH+3], $time);
        if (got[NCH+2:NCH+1] !== e[NCH+2:NCH+1])
          $display("FAIL R4 (%s) shift clocks got %b exp %b at t=%0t", t, got[NCH+2:NCH+1], e[NCH+2:NCH+1], $time);
        if (got[NCH] !== e[NCH])
          $display("FAIL R5 (%s) line_active got %b exp %b at t=%0t", t, got[NCH], e[NCH], $time);
        if (got[NCH-1:0] !== e[NCH-1:0])
          $display("FAIL R6/R7 (%s) strobes got %b exp %b at t=%0t", t, got[NCH-1:0], e[NCH-1:0], $time);
      end
      if (shclk_a && !prev_a) rise_cnt++;
      for (int k = 0; k < NCH; k++) if (chan_strobe[k]) order_q.push_back(k);
    end
    prev_a = shclk_a;
  end

  task automatic expect_int(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d exp %0d", tag, got, exp);
    end
  endtask

  // Runs one line; configuration ports are scrambled after capture (R11)
  task automatic run_line(input int o, input int l, input bit dr, input string tag,
                          input int cyc, input bit count_chk);
    scen = tag;
    dir_right = dr;
    ofs_cfg = 8'(o);
    len_cfg = 8'(l);
    step(1'b1, o, l, dr);
    rise_cnt = 0;
    order_q.delete();
    ofs_cfg = 8'(o + 37);
    len_cfg = 8'(l + 3);
    for (int i = 0; i < cyc; i++) step(1'b0, 0, 0, dr);
    if (count_chk) begin
      expect_int({"R5 clock rises ", tag}, rise_cnt, l);
      expect_int({"R6/R7 strobe count ", tag}, order_q.size(), l * NCH);
      if (l > 0 && order_q.size() >= NCH)
        for (int k = 0; k < NCH; k++)
          expect_int(dr ? "R6 right order" : "R7 left order", order_q[k], dr ? k : NCH - 1 - k);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if ({scan_start, shclk_a, shclk_b, line_active, chan_strobe} !== {4'b0010, {NCH{1'b0}}}) begin
      errors++;
      $display("FAIL R1 reset outputs got %b exp %b",
               {scan_start, shclk_a, shclk_b, line_active, chan_strobe}, {4'b0010, {NCH{1'b0}}});
    end
    rst = 1'b0;
    mon_on = 1;
    for (int i = 0; i < 5; i++) step(1'b0, 0, 0, 1'b1);
    run_line(3, 4, 1'b1, "R6 right O3 L4", 3 + 4 * DIV + DIV + 10, 1);
    run_line(0, 1, 1'b0, "R7 left O0 L1", 1 * DIV + DIV + 10, 1);
    run_line(7, 108, 1'b1, "R11 full line", 7 + 108 * DIV + DIV + 10, 1);
    run_line(2, 3, 1'b0, "R7 left O2 L3", 2 + 3 * DIV + DIV + 10, 1);
    run_line(2, 0, 1'b1, "R10 zero length", 2 + DIV + 10, 1);
    run_line(1, 5, 1'b1, "R9 cut line", 20, 0);
    run_line(0, 2, 1'b1, "R9 restart", 2 * DIV + DIV + 10, 1);
    scen = "R8 idle";
    for (int i = 0; i < 20; i++) step(1'b0, 0, 0, 1'b1);
    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule